// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block is the device-side status logic of a parallel NOR flash. While the array is being programmed or erased, a host polls the part with ordinary read cycles. This block decides what those reads return. It returns either the array word supplied by the array read path, or a status byte whose bits depend on several things: the operation type, whether an erase is suspended, which sector the read targets, and whether the target was protected.

A command decoder in front of this block issues start pulses for a program (target sector and the most significant bit of the word being written) or for a sector erase (a sector-select mask). It also issues suspend and resume requests. A behavioural array timer reports completion of real operations with a done pulse. Operations aimed only at protected storage never reach the array. Instead, the block holds the status busy for a parameterised number of clock cycles and then drops back.

The controller is a state machine with eight states:

| State | Meaning |
|---|---|
| ST_IDLE | Idle. |
| ST_PROG | Program running. |
| ST_PROG_LOCK | Protected-program hold. |
| ST_ERASE | Erase running. |
| ST_ERASE_LOCK | Fully protected erase hold. |
| ST_SUSP | Erase suspended. |
| ST_SUSP_PROG | Program during suspend. |
| ST_SUSP_LOCK | Refused program during suspend. |

Its transitions are:

- IDLE to PROG, or to PROG_LOCK, on a program start.
- IDLE to ERASE, or to ERASE_LOCK, on an erase start.
- PROG to IDLE on done.
- PROG_LOCK to IDLE on hold expiry.
- ERASE to IDLE on done.
- ERASE to SUSP on a suspend request.
- ERASE_LOCK to IDLE on hold expiry.
- SUSP to ERASE on a resume request.
- SUSP to SUSP_PROG, or to SUSP_LOCK, on a program start.
- SUSP_PROG to SUSP on done.
- SUSP_LOCK to SUSP on hold expiry.

Top module: `nor_status_engine`

## Requirements
- R1: `ready_o` is 0 in PROG, PROG_LOCK, ERASE, ERASE_LOCK, SUSP_PROG and SUSP_LOCK. It is 1 in IDLE and SUSP. It falls in the first cycle after an accepted start, and it is 1 straight out of reset.
- R2: A read strobe is answered one cycle later with `rd_valid` high for one cycle and the byte on `rd_data`. Both outputs reset to 0. In a status byte, bit 7 is the polling bit, bit 6 is the operation toggle, bit 2 is the sector toggle, and all other bits are 0.
- R3: While any program is active, the polling bit is the inverse of `prog_poll`. In IDLE, every read returns `arr_rdata` as sampled with the strobe, and so does a read after the done pulse has returned the block to IDLE.
- R4: During an erase the polling bit is 0. After a suspend request in ERASE, `ready_o` is 1, and reads to a suspended sector return polling bit 1 with the operation toggle held still.
- R5: The operation toggle (bit 6) inverts after every read, at any sector, in PROG, PROG_LOCK, ERASE, ERASE_LOCK, SUSP_PROG and SUSP_LOCK. It does not invert in any other state.
- R6: A program in IDLE to a protected sector holds status busy for exactly PROG_TO cycles, then returns to IDLE without any done pulse.
- R7: An erase whose mask has no unprotected sector holds status busy for ERASE_TO cycles, reporting polling bit 0 and a toggling bit 6. Suspend and done pulses are ignored during that hold, and the block then returns to IDLE.
- R8: An erase start records only the selected sectors that are not protected. Selected but protected sectors are treated as not being erased.
- R9: The sector toggle (bit 2) inverts after each read to a recorded erase sector in ERASE, SUSP, SUSP_PROG and SUSP_LOCK. In every other status read it is 1, including reads during a program outside suspend.
- R10: In SUSP, reads to sectors that are not suspended return `arr_rdata`. A resume request returns the block to ERASE.
- R11: A program in SUSP to an unprotected sector outside the erase set runs until done and then returns to SUSP. A program to a protected or suspended sector holds for PROG_TO cycles and then returns to SUSP.
- R12: Several pulses in the same cycle are ordered as follows. Program start beats erase start in IDLE. Done beats suspend in ERASE. Resume beats program start in SUSP. Starts are ignored in busy states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Program start pulse |
| prog_sect | input | SECT_W | Target sector of the program |
| prog_poll | input | 1 | Most significant bit of the word being programmed |
| erase_start | input | 1 | Sector erase start pulse |
| erase_sel | input | NUM_SECT | Sectors selected for erase |
| protect | input | NUM_SECT | Per-sector write protection |
| suspend_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| op_done | input | 1 | Completion pulse from the array timer |
| rd_stb | input | 1 | Read cycle strobe |
| rd_sect | input | SECT_W | Sector addressed by the read |
| arr_rdata | input | DATA_W | Array word for the read address |
| ready_o | output | 1 | Ready (1) or busy (0) |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Status byte or array word |

## Verification
The reads are spread across three kinds of sector: sectors in the recorded erase set, sectors that were selected but protected, and sectors never selected. This separates the operation toggle, which moves for any sector, from the sector toggle, which moves only for erasing or suspended sectors. Program words with the top bit at 1 and at 0 show that the polling bit is an inversion and not a constant. Protected programs and protected erases are run with reads inside the hold and with a cycle-exact end check. Simultaneous pulse pairs (start and start, done and suspend, resume and program) pin down each priority.

// File: rtl/nor_status_pkg.sv
package nor_status_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PROG_LOCK,
        ST_ERASE,
        ST_ERASE_LOCK,
        ST_SUSP,
        ST_SUSP_PROG,
        ST_SUSP_LOCK
    } nse_state_e;

    // status byte bit positions decoded by host polling loops
    localparam int POLL_BIT = 7;
    localparam int OPTOG_BIT = 6;
    localparam int SECTOG_BIT = 2;

    // states in which the array (or a hold timer) is busy
    function automatic logic nse_busy(input nse_state_e s);
        return (s == ST_PROG) || (s == ST_PROG_LOCK) || (s == ST_ERASE) ||
               (s == ST_ERASE_LOCK) || (s == ST_SUSP_PROG) || (s == ST_SUSP_LOCK);
    endfunction

    // states in which the recorded erase set is live
    function automatic logic nse_erase_live(input nse_state_e s);
        return (s == ST_ERASE) || (s == ST_SUSP) || (s == ST_SUSP_PROG) ||
               (s == ST_SUSP_LOCK);
    endfunction

    // states reporting a program in the polling bit
    function automatic logic nse_prog_kind(input nse_state_e s);
        return (s == ST_PROG) || (s == ST_PROG_LOCK) || (s == ST_SUSP_PROG) ||
               (s == ST_SUSP_LOCK);
    endfunction

endpackage

// File: rtl/nse_sect_dec.sv
module nse_sect_dec #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W = $clog2(NUM_SECT)
) (
    input  logic [SECT_W-1:0]   idx,
    output logic [NUM_SECT-1:0] hit
);
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        assign hit[g] = (idx == SECT_W'(g));
    end
endmodule

// File: rtl/nse_lock_timer.sv
module nse_lock_timer #(
    parameter int PROG_TO  = 100,
    parameter int ERASE_TO = 10000,
    localparam int MAX_TO  = (PROG_TO > ERASE_TO) ? PROG_TO : ERASE_TO,
    localparam int CNT_W   = $clog2(MAX_TO + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_sel,
    output logic expire
);
    localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_TO - 1);
    localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_TO - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign expire = run && (cnt == (long_sel ? E_LAST : P_LAST));
endmodule

// File: rtl/nse_toggle_pair.sv
module nse_toggle_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_op,
    input  logic flip_sect,
    output logic op_tog,
    output logic sect_tog
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_tog   <= 1'b0;
            sect_tog <= 1'b0;
        end else begin
            if (flip_op) begin
                op_tog <= ~op_tog;
            end
            if (flip_sect) begin
                sect_tog <= ~sect_tog;
            end
        end
    end
endmodule

// File: rtl/nor_status_engine.sv
module nor_status_engine
    import nor_status_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int DATA_W   = 8,
    parameter int PROG_TO  = 100,
    parameter int ERASE_TO = 10000,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_start,
    input  logic [SECT_W-1:0]   prog_sect,
    input  logic                prog_poll,
    input  logic                erase_start,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic [NUM_SECT-1:0] protect,
    input  logic                suspend_req,
    input  logic                resume_req,
    input  logic                op_done,
    input  logic                rd_stb,
    input  logic [SECT_W-1:0]   rd_sect,
    input  logic [DATA_W-1:0]   arr_rdata,
    output logic                ready_o,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);

    nse_state_e state, state_nx;

    logic [NUM_SECT-1:0] eset;
    logic                poll_q;
    logic [NUM_SECT-1:0] prog_hit;
    logic [NUM_SECT-1:0] rd_hit;
    logic [NUM_SECT-1:0] erase_eff;
    logic                prog_prot;
    logic                prog_in_eset;
    logic                rd_in_eset;
    logic                lock_run;
    logic                lock_long;
    logic                lock_expire;
    logic                op_tog;
    logic                sect_tog;
    logic                flip_op;
    logic                flip_sect;
    logic                take_prog_idle;
    logic                take_prog_susp;
    logic                take_erase;
    logic                status_view;
    logic [DATA_W-1:0]   status_byte;
    logic [DATA_W-1:0]   rd_mux;

    // ---------------------------------------------------------------
    // sector decoding for program target and read address
    // ---------------------------------------------------------------
    nse_sect_dec #(.NUM_SECT(NUM_SECT)) u_prog_dec (
        .idx (prog_sect),
        .hit (prog_hit)
    );

    nse_sect_dec #(.NUM_SECT(NUM_SECT)) u_rd_dec (
        .idx (rd_sect),
        .hit (rd_hit)
    );

    assign erase_eff    = erase_sel & ~protect;
    assign prog_prot    = |(prog_hit & protect);
    assign prog_in_eset = |(prog_hit & eset);
    assign rd_in_eset   = |(rd_hit & eset);

    // ---------------------------------------------------------------
    // hold timer for operations that never reach the array
    // ---------------------------------------------------------------
    assign lock_run  = (state == ST_PROG_LOCK) || (state == ST_ERASE_LOCK) ||
                       (state == ST_SUSP_LOCK);
    assign lock_long = (state == ST_ERASE_LOCK);

    nse_lock_timer #(.PROG_TO(PROG_TO), .ERASE_TO(ERASE_TO)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (lock_run),
        .long_sel (lock_long),
        .expire   (lock_expire)
    );

    // ---------------------------------------------------------------
    // command acceptance
    // ---------------------------------------------------------------
    assign take_prog_idle = (state == ST_IDLE) && prog_start;
    assign take_erase     = (state == ST_IDLE) && erase_start && !prog_start;
    assign take_prog_susp = (state == ST_SUSP) && prog_start && !resume_req;

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------------------------------------------------------
    // next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (prog_start) begin
                    state_nx = prog_prot ? ST_PROG_LOCK : ST_PROG;
                end else if (erase_start) begin
                    state_nx = (erase_eff == '0) ? ST_ERASE_LOCK : ST_ERASE;
                end
            end
            ST_PROG: begin
                if (op_done) state_nx = ST_IDLE;
            end
            ST_PROG_LOCK: begin
                if (lock_expire) state_nx = ST_IDLE;
            end
            ST_ERASE: begin
                if (op_done) begin
                    state_nx = ST_IDLE;
                end else if (suspend_req) begin
                    state_nx = ST_SUSP;
                end
            end
            ST_ERASE_LOCK: begin
                if (lock_expire) state_nx = ST_IDLE;
            end
            ST_SUSP: begin
                if (resume_req) begin
                    state_nx = ST_ERASE;
                end else if (prog_start) begin
                    state_nx = (prog_prot || prog_in_eset) ? ST_SUSP_LOCK : ST_SUSP_PROG;
                end
            end
            ST_SUSP_PROG: begin
                if (op_done) state_nx = ST_SUSP;
            end
            ST_SUSP_LOCK: begin
                if (lock_expire) state_nx = ST_SUSP;
            end
        endcase
    end

    // ---------------------------------------------------------------
    // captured operation context
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eset   <= '0;
            poll_q <= 1'b0;
        end else begin
            if (take_erase) begin
                eset <= erase_eff;
            end
            if (take_prog_idle || take_prog_susp) begin
                poll_q <= prog_poll;
            end
        end
    end

    // ---------------------------------------------------------------
    // toggle bits
    // ---------------------------------------------------------------
    assign flip_op   = rd_stb && nse_busy(state);
    assign flip_sect = rd_stb && rd_in_eset && nse_erase_live(state);

    nse_toggle_pair u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .flip_op   (flip_op),
        .flip_sect (flip_sect),
        .op_tog    (op_tog),
        .sect_tog  (sect_tog)
    );

    // ---------------------------------------------------------------
    // read data selection
    // ---------------------------------------------------------------
    always_comb begin
        status_byte = '0;
        unique case (state)
            ST_PROG, ST_PROG_LOCK, ST_SUSP_PROG, ST_SUSP_LOCK:
                status_byte[POLL_BIT] = ~poll_q;
            ST_SUSP:
                status_byte[POLL_BIT] = 1'b1;
            ST_IDLE, ST_ERASE, ST_ERASE_LOCK:
                status_byte[POLL_BIT] = 1'b0;
        endcase
        status_byte[OPTOG_BIT]  = op_tog;
        status_byte[SECTOG_BIT] = (rd_in_eset && nse_erase_live(state)) ? sect_tog : 1'b1;
    end

    assign status_view = (state != ST_IDLE) && !((state == ST_SUSP) && !rd_in_eset);
    assign rd_mux      = status_view ? status_byte : arr_rdata;

    // ---------------------------------------------------------------
    // output process
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rd_data <= rd_mux;
            end
        end
    end

    assign ready_o = (state == ST_IDLE) || (state == ST_SUSP);

endmodule

// File: rtl/nor_status_engine_chk.sv
module nor_status_engine_chk
    import nor_status_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int DATA_W   = 8,
    parameter int PROG_TO  = 100,
    parameter int ERASE_TO = 10000,
    localparam int LK_W    = $clog2(PROG_TO + ERASE_TO + 2)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                prog_start,
    input logic                suspend_req,
    input logic                op_done,
    input logic                rd_stb,
    input logic [DATA_W-1:0]   arr_rdata,
    input logic                ready_o,
    input logic                rd_valid,
    input logic [DATA_W-1:0]   rd_data,
    input nse_state_e          state,
    input logic [NUM_SECT-1:0] eset
);
    logic [LK_W-1:0] lk_cnt;
    logic            in_lock;
    logic            erase_fam;

    assign in_lock   = (state == ST_PROG_LOCK) || (state == ST_ERASE_LOCK) ||
                       (state == ST_SUSP_LOCK);
    assign erase_fam = (state == ST_ERASE) || (state == ST_SUSP) ||
                       (state == ST_SUSP_PROG) || (state == ST_SUSP_LOCK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_cnt <= '0;
        end else if (in_lock) begin
            lk_cnt <= lk_cnt + 1'b1;
        end else begin
            lk_cnt <= '0;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start && ready_o |=> !ready_o); // R1

    AST_RD_VALID_HI: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid); // R2

    AST_RD_VALID_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid); // R2

    AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && (state == ST_IDLE) |=> rd_data == $past(arr_rdata)); // R3

    AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) && suspend_req && !op_done |=> ready_o); // R4

    AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PROG_LOCK) || (state == ST_SUSP_LOCK)) |-> lk_cnt < LK_W'(PROG_TO)); // R6

    AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_LOCK) |-> lk_cnt < LK_W'(ERASE_TO)); // R7

    AST_ESET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fam && $past(erase_fam) |-> $stable(eset)); // R8

endmodule

bind nor_status_engine nor_status_engine_chk #(
    .NUM_SECT (NUM_SECT),
    .DATA_W   (DATA_W),
    .PROG_TO  (PROG_TO),
    .ERASE_TO (ERASE_TO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_start  (prog_start),
    .suspend_req (suspend_req),
    .op_done     (op_done),
    .rd_stb      (rd_stb),
    .arr_rdata   (arr_rdata),
    .ready_o     (ready_o),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .state       (state),
    .eset        (eset)
);

// File: tb/nor_status_engine_tb.sv
module nor_status_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SECT   = 8;
    localparam int SECT_W     = 3;
    localparam int DATA_W     = 8;
    localparam int PROG_TO    = 20;
    localparam int ERASE_TO   = 50;

    localparam int M_IDLE = 0, M_PROG = 1, M_PLOCK = 2, M_ERASE = 3;
    localparam int M_ELOCK = 4, M_SUSP = 5, M_SPROG = 6, M_SPLOCK = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                prog_start = 1'b0;
    logic [SECT_W-1:0]   prog_sect = '0;
    logic                prog_poll = 1'b0;
    logic                erase_start = 1'b0;
    logic [NUM_SECT-1:0] erase_sel = '0;
    logic [NUM_SECT-1:0] protect = '0;
    logic                suspend_req = 1'b0;
    logic                resume_req = 1'b0;
    logic                op_done = 1'b0;
    logic                rd_stb = 1'b0;
    logic [SECT_W-1:0]   rd_sect = '0;
    logic [DATA_W-1:0]   arr_rdata = '0;
    logic                ready_o;
    logic                rd_valid;
    logic [DATA_W-1:0]   rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int                  m_mode = M_IDLE;
    logic                m_p7 = 1'b0;
    logic [NUM_SECT-1:0] m_eset = '0;
    logic                m_t6 = 1'b0;
    logic                m_t2 = 1'b0;

    // scoreboard
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic [DATA_W-1:0] mon_e;
    string             mon_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_status_engine #(
        .NUM_SECT (NUM_SECT),
        .DATA_W   (DATA_W),
        .PROG_TO  (PROG_TO),
        .ERASE_TO (ERASE_TO)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_start  (prog_start),
        .prog_sect   (prog_sect),
        .prog_poll   (prog_poll),
        .erase_start (erase_start),
        .erase_sel   (erase_sel),
        .protect     (protect),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .op_done     (op_done),
        .rd_stb      (rd_stb),
        .rd_sect     (rd_sect),
        .arr_rdata   (arr_rdata),
        .ready_o     (ready_o),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_busy(input int m);
        return m inside {M_PROG, M_PLOCK, M_ERASE, M_ELOCK, M_SPROG, M_SPLOCK};
    endfunction

    task automatic chk_ready(input string req);
        check(req, 32'(ready_o), 32'(!m_busy(m_mode)));
    endtask

    // driver: compute expected byte, queue it, issue the read
    task automatic do_read(input logic [SECT_W-1:0] sect, input logic [DATA_W-1:0] arr,
                           input string req);
        logic [DATA_W-1:0] e;
        bit insel, zone;
        insel = m_eset[sect];
        zone  = insel && (m_mode inside {M_ERASE, M_SUSP, M_SPROG, M_SPLOCK});
        if (m_mode == M_IDLE || (m_mode == M_SUSP && !insel)) begin
            e = arr;
        end else begin
            e = '0;
            if (m_mode inside {M_PROG, M_PLOCK, M_SPROG, M_SPLOCK}) e[7] = ~m_p7;
            else e[7] = (m_mode == M_SUSP);
            e[6] = m_t6;
            e[2] = zone ? m_t2 : 1'b1;
        end
        if (m_busy(m_mode)) m_t6 = ~m_t6;
        if (zone) m_t2 = ~m_t2;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        rd_stb = 1'b1; rd_sect = sect; arr_rdata = arr;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic start_prog(input logic [SECT_W-1:0] sect, input logic p7);
        @(negedge clk);
        prog_start = 1'b1; prog_sect = sect; prog_poll = p7;
        @(negedge clk);
        prog_start = 1'b0;
        if (m_mode == M_IDLE) begin
            m_mode = protect[sect] ? M_PLOCK : M_PROG;
            m_p7 = p7;
        end else if (m_mode == M_SUSP) begin
            m_mode = (protect[sect] || m_eset[sect]) ? M_SPLOCK : M_SPROG;
            m_p7 = p7;
        end
    endtask

    task automatic start_erase(input logic [NUM_SECT-1:0] sel);
        @(negedge clk);
        erase_start = 1'b1; erase_sel = sel;
        @(negedge clk);
        erase_start = 1'b0;
        if (m_mode == M_IDLE) begin
            m_eset = sel & ~protect;
            m_mode = (m_eset == '0) ? M_ELOCK : M_ERASE;
        end
    endtask

    task automatic pulse_suspend();
        @(negedge clk); suspend_req = 1'b1;
        @(negedge clk); suspend_req = 1'b0;
        if (m_mode == M_ERASE) m_mode = M_SUSP;
    endtask

    task automatic pulse_resume();
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
        if (m_mode == M_SUSP) m_mode = M_ERASE;
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        if (m_mode == M_PROG || m_mode == M_ERASE) m_mode = M_IDLE;
        else if (m_mode == M_SPROG) m_mode = M_SUSP;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R2 unexpected read result actual=%0h expected=none", rd_data);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, 32'(rd_data), 32'(mon_e));
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // reset state
        check("R1 reset ready", 32'(ready_o), 32'd1);
        check("R2 reset valid", 32'(rd_valid), 32'd0);
        check("R2 reset data", 32'(rd_data), 32'd0);
        do_read(3'd4, 8'h3C, "R3 idle array read");

        // plain program, top bit 1 then 0
        start_prog(3'd1, 1'b1);
        chk_ready("R1 busy after program start");
        do_read(3'd1, 8'h11, "R3 R5 program poll first");
        do_read(3'd6, 8'h22, "R5 R9 program other sector");
        do_read(3'd1, 8'h33, "R5 program poll third");
        pulse_done();
        chk_ready("R1 ready after done");
        do_read(3'd1, 8'h81, "R3 array after program");
        start_prog(3'd2, 1'b0);
        do_read(3'd2, 8'h44, "R3 inverted zero bit");
        pulse_done();

        // erase with one selected sector protected
        protect = 8'b0000_0100;
        start_erase(8'b0000_0110);
        chk_ready("R1 busy during erase");
        do_read(3'd1, 8'h55, "R4 R9 erasing sector");
        do_read(3'd2, 8'h66, "R8 protected selected sector");
        do_read(3'd5, 8'h77, "R9 unselected sector");
        do_read(3'd1, 8'h88, "R9 erasing sector again");
        pulse_suspend();
        chk_ready("R4 ready in suspend");
        do_read(3'd1, 8'h99, "R4 suspended sector");
        do_read(3'd1, 8'h9A, "R4 R9 suspended sector hold");
        do_read(3'd3, 8'hAB, "R10 array in suspend");
        do_read(3'd2, 8'hAC, "R8 R10 protected skipped sector reads array");

        // program during suspend
        start_prog(3'd3, 1'b0);
        chk_ready("R11 busy suspend program");
        do_read(3'd0, 8'h01, "R11 R5 suspend program status");
        do_read(3'd1, 8'h02, "R11 R9 suspend program erase sector");
        pulse_done();
        chk_ready("R11 back to suspend");
        start_prog(3'd1, 1'b1);
        chk_ready("R11 refused program busy");
        do_read(3'd1, 8'h03, "R11 refused program status");
        wait_cyc(PROG_TO);
        m_mode = M_SUSP;
        chk_ready("R11 refused program ends in suspend");
        do_read(3'd1, 8'h04, "R11 suspend status after hold");

        // resume beats program start
        @(negedge clk);
        resume_req = 1'b1; prog_start = 1'b1; prog_sect = 3'd5; prog_poll = 1'b1;
        @(negedge clk);
        resume_req = 1'b0; prog_start = 1'b0;
        m_mode = M_ERASE;
        do_read(3'd1, 8'h05, "R12 R10 resume wins");
        // done beats suspend
        @(negedge clk);
        op_done = 1'b1; suspend_req = 1'b1;
        @(negedge clk);
        op_done = 1'b0; suspend_req = 1'b0;
        m_mode = M_IDLE;
        chk_ready("R12 done wins");
        do_read(3'd1, 8'h06, "R12 idle after erase");

        // fully protected erase
        protect = 8'h0F;
        start_erase(8'h03);
        chk_ready("R7 protected erase busy");
        do_read(3'd0, 8'h07, "R7 protected erase status");
        pulse_suspend();
        chk_ready("R7 suspend ignored");
        pulse_done();
        chk_ready("R7 done ignored");
        do_read(3'd1, 8'h08, "R7 protected erase status again");
        wait_cyc(ERASE_TO);
        m_mode = M_IDLE;
        chk_ready("R7 hold over");
        do_read(3'd0, 8'h09, "R7 array after hold");

        // protected program: status then exact hold length
        protect = 8'h01;
        start_prog(3'd0, 1'b1);
        do_read(3'd0, 8'h0A, "R6 protected program status");
        wait_cyc(PROG_TO);
        m_mode = M_IDLE;
        do_read(3'd0, 8'h0B, "R6 array after hold");
        start_prog(3'd0, 1'b0);
        wait_cyc(PROG_TO - 1);
        check("R6 still held at last cycle", 32'(ready_o), 32'd0);
        wait_cyc(1);
        m_mode = M_IDLE;
        check("R6 released after hold", 32'(ready_o), 32'd1);

        // program start beats erase start; starts ignored while busy
        protect = 8'h00;
        @(negedge clk);
        prog_start = 1'b1; prog_sect = 3'd6; prog_poll = 1'b1;
        erase_start = 1'b1; erase_sel = 8'hF0;
        @(negedge clk);
        prog_start = 1'b0; erase_start = 1'b0;
        m_mode = M_PROG; m_p7 = 1'b1;
        do_read(3'd1, 8'h0C, "R12 program wins over erase");
        start_erase(8'h80);
        do_read(3'd7, 8'h0D, "R12 erase ignored while busy");
        pulse_done();
        chk_ready("R12 idle after program");
        do_read(3'd7, 8'h0E, "R12 array after program");

        wait_cyc(4);
        check("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule